// File: doc/BRIEF.md
# Bufferless Honeycomb Mesh Router

This block is the switching element at one node of a honeycomb mesh of compute elements. A node has four ports: a local port for injection and ejection, a north link, a south link, and a single horizontal link. Whether the horizontal link points toward +X or −X depends on the node's position in the mesh, and a parameter selects which. Each flit carries a 9-bit control header that holds the signed X and Y hops still to travel. The router picks an output from the header, moves the offset on the axis it travels one step toward zero, and passes the flit through a crossbar. All of this is combinational, so a flit that is granted leaves in the same clock cycle it is presented.

The router stores no flits. An input that cannot be served sees its ready low and must hold its flit until a later cycle. Every flit names a virtual channel, and the downstream side gives one ready bit per virtual channel on each output. A flit can only be forwarded when its own channel is free, so a stalled channel does not block traffic on another channel of the same link. When several inputs want the same output in one cycle, a round-robin arbiter for that output picks one. The crossbar never sends a flit back out of the port it came in on.

Top module: `hc_router`

## Requirements
- R1: A valid flit whose route is allowed and whose output channel is ready appears on its output port in the same clock cycle, with its input ready high. Inputs that go to different outputs are all forwarded in that one cycle. Ready is never high on an input that is not valid.
- R2: A flit is {header, payload}. The payload is the low DATA_W bits. The header sits above the payload and holds, from the most significant bit down: bit 8 header-valid, bits 7:4 X offset, bits 3:0 Y offset. Both offsets are 4-bit two's complement. The payload is forwarded unchanged.
- R3: X goes first. If the X offset is nonzero and the node's horizontal link points toward its sign (toward +X when HORIZ_EAST=1), the flit leaves on the horizontal port. Its X offset moves one step toward zero and its Y offset is unchanged.
- R4: With X offset zero, a positive Y offset goes north and is decremented by one, and a negative Y offset goes south and is incremented by one. With both offsets zero, the flit goes to the local port and its header is unchanged.
- R5: Detour. If the X offset is nonzero but the node has no link in that direction, the flit takes a vertical link and its X offset is kept. With a nonzero Y offset it follows R4. With a zero Y offset it goes north (Y becomes −1), or south (Y becomes +1) if it entered on the north port.
- R6: No loopback. A flit whose route equals the port it entered on is never granted. Its input ready stays low and no output becomes valid for it.
- R7: A valid flit whose header-valid bit is 0 is taken (ready high) and discarded, and no output becomes valid.
- R8: The virtual channel of a flit is kept on output. A flit is forwarded only if the downstream ready bit out_ready[o*NUM_VC+vc] is high. Otherwise its input ready is low, while another channel may use the same output in that cycle.
- R9: Each output grants at most one input per cycle. Arbitration is round-robin: after input i wins an output, priority for that output starts at input i+1. The pointer resets to input 0.
- R10: Port numbers are 0 local, 1 north, 2 south, 3 horizontal. After reset with no valid input, every out_valid and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the arbiter pointers |
| in_valid | input | 4 | Per input port, flit present |
| in_ready | output | 4 | Per input port, flit taken this cycle |
| in_vc | input | 4*VC_W | Per input port, virtual channel of the flit |
| in_flit | input | 4*(DATA_W+9) | Per input port, header and payload |
| out_valid | output | 4 | Per output port, flit driven this cycle |
| out_ready | input | 4*NUM_VC | Per output port, one ready bit per virtual channel |
| out_vc | output | 4*VC_W | Per output port, virtual channel of the flit |
| out_flit | output | 4*(DATA_W+9) | Per output port, flit with updated header |

## Verification
Single flits are sent from different input ports with offsets of each sign. These separate the X-first path, the Y path, local ejection and both forms of the detour, and they show the header update for each direction. Some patterns put flits on all four inputs toward four different outputs, which shows the crossbar serving them in parallel within one cycle. Other patterns send three inputs to one output and hold them there for several cycles, which gives the round-robin order. A flit with a routed-back header and a flit with the header-valid bit cleared tell blocking apart from discarding. A downstream ready bit held low for one channel, with a second flit on another channel, shows that the channels are independent on a shared link.

// File: rtl/hc_pkg.sv
package hc_pkg;

  localparam int NPORT = 4;
  localparam int HDR_W = 9;

  typedef enum logic [1:0] {
    P_LOCAL = 2'd0,
    P_NORTH = 2'd1,
    P_SOUTH = 2'd2,
    P_HORIZ = 2'd3
  } port_e;

  typedef struct packed {
    logic       hv;
    logic [3:0] dx;
    logic [3:0] dy;
  } hdr_t;

  typedef struct packed {
    port_e dir;
    hdr_t  hdr;
  } route_t;

  // One routing decision: pick the output and step the travelled offset.
  function automatic route_t route_step(hdr_t h, port_e from, logic horiz_east);
    route_t r;
    logic signed [3:0] x;
    logic signed [3:0] y;
    logic x_ok;
    x = $signed(h.dx);
    y = $signed(h.dy);
    r.hdr = h;
    r.dir = P_LOCAL;
    x_ok = horiz_east ? (x > 4'sd0) : (x < 4'sd0);
    if (x != 4'sd0 && x_ok) begin
      r.dir    = P_HORIZ;
      r.hdr.dx = horiz_east ? h.dx - 4'd1 : h.dx + 4'd1;
    end else if (y > 4'sd0) begin
      r.dir    = P_NORTH;
      r.hdr.dy = h.dy - 4'd1;
    end else if (y < 4'sd0) begin
      r.dir    = P_SOUTH;
      r.hdr.dy = h.dy + 4'd1;
    end else if (x != 4'sd0) begin
      if (from == P_NORTH) begin
        r.dir    = P_SOUTH;
        r.hdr.dy = h.dy + 4'd1;
      end else begin
        r.dir    = P_NORTH;
        r.hdr.dy = h.dy - 4'd1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/hc_route.sv
module hc_route
  import hc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PORT_ID    = 0,
  parameter bit HORIZ_EAST = 1'b1
) (
  input  logic                    valid,
  input  logic [DATA_W+HDR_W-1:0] flit_i,
  output logic                    req,
  output port_e                   dir,
  output logic [DATA_W+HDR_W-1:0] flit_o,
  output logic                    drop
);
  localparam int    FW      = DATA_W + HDR_W;
  localparam port_e MY_PORT = port_e'(PORT_ID);

  hdr_t   hdr_in;
  route_t rt;

  assign hdr_in = hdr_t'(flit_i[FW-1 -: HDR_W]);
  assign rt     = route_step(hdr_in, MY_PORT, HORIZ_EAST);
  assign dir    = rt.dir;
  assign drop   = valid & ~hdr_in.hv;
  assign req    = valid & hdr_in.hv & (rt.dir != MY_PORT);
  assign flit_o = {rt.hdr, flit_i[DATA_W-1:0]};
endmodule

// File: rtl/hc_rr_arb.sv
module hc_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;
  logic          found;

  always_comb begin
    gnt   = '0;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        win      = PW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (found) begin
      ptr <= PW'((int'(win) + 1) % N);
    end
  end
endmodule

// File: rtl/hc_router.sv
module hc_router
  import hc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_VC     = 4,
  parameter bit HORIZ_EAST = 1'b1,
  parameter int VC_W       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPORT-1:0]               in_valid,
  output logic [NPORT-1:0]               in_ready,
  input  logic [NPORT*VC_W-1:0]          in_vc,
  input  logic [NPORT*(DATA_W+HDR_W)-1:0] in_flit,
  output logic [NPORT-1:0]               out_valid,
  input  logic [NPORT*NUM_VC-1:0]        out_ready,
  output logic [NPORT*VC_W-1:0]          out_vc,
  output logic [NPORT*(DATA_W+HDR_W)-1:0] out_flit
);
  localparam int FW = DATA_W + HDR_W;

  logic [NPORT-1:0] req_i;
  logic [NPORT-1:0] drop_i;
  port_e            dir_i    [NPORT];
  logic [FW-1:0]    fwd_flit [NPORT];
  logic [VC_W-1:0]  vc_i     [NPORT];
  logic [NPORT-1:0] req_mat  [NPORT];
  logic [NPORT-1:0] gnt_mat  [NPORT];

  // Named crossbar events, flattened for the checker.
  logic [NPORT*NPORT-1:0] req_flat;
  logic [NPORT*NPORT-1:0] gnt_flat;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    hc_route #(
      .DATA_W(DATA_W), .PORT_ID(i), .HORIZ_EAST(HORIZ_EAST)
    ) u_route (
      .valid (in_valid[i]),
      .flit_i(in_flit[i*FW +: FW]),
      .req   (req_i[i]),
      .dir   (dir_i[i]),
      .flit_o(fwd_flit[i]),
      .drop  (drop_i[i])
    );
    assign vc_i[i] = in_vc[i*VC_W +: VC_W];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [FW-1:0]   sel_flit;
    logic [VC_W-1:0] sel_vc;

    for (genvar i = 0; i < NPORT; i++) begin : g_req
      assign req_mat[o][i] = req_i[i] && (dir_i[i] == port_e'(o))
                             && out_ready[o*NUM_VC + int'(vc_i[i])];
    end

    hc_rr_arb #(.N(NPORT)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req_mat[o]),
      .gnt  (gnt_mat[o])
    );

    always_comb begin
      sel_flit = '0;
      sel_vc   = '0;
      for (int i = 0; i < NPORT; i++) begin
        if (gnt_mat[o][i]) begin
          sel_flit = fwd_flit[i];
          sel_vc   = vc_i[i];
        end
      end
    end

    assign out_valid[o]               = |gnt_mat[o];
    assign out_flit[o*FW +: FW]       = sel_flit;
    assign out_vc[o*VC_W +: VC_W]     = sel_vc;
    assign req_flat[o*NPORT +: NPORT] = req_mat[o];
    assign gnt_flat[o*NPORT +: NPORT] = gnt_mat[o];
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      in_ready[i] = drop_i[i];
      for (int o = 0; o < NPORT; o++) begin
        in_ready[i] = in_ready[i] | gnt_flat[o*NPORT + i];
      end
    end
  end
endmodule

// File: rtl/hc_router_chk.sv
module hc_router_chk #(
  parameter int NPORT  = 4,
  parameter int NUM_VC = 4,
  parameter int VC_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORT-1:0]         in_valid,
  input logic [NPORT-1:0]         in_ready,
  input logic [NPORT-1:0]         out_valid,
  input logic [NPORT*NUM_VC-1:0]  out_ready,
  input logic [NPORT*VC_W-1:0]    out_vc,
  input logic [NPORT-1:0]         drop_i,
  input logic [NPORT*NPORT-1:0]   req_flat,
  input logic [NPORT*NPORT-1:0]   gnt_flat
);
  for (genvar i = 0; i < NPORT; i++) begin : g_col
    logic [NPORT-1:0] col;
    for (genvar o = 0; o < NPORT; o++) begin : g_bit
      assign col[o] = gnt_flat[o*NPORT + i];
    end

    p_one_output_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
    p_ready_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> in_valid[i]);
    p_drop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drop_i[i] |-> (col == '0));
    p_no_loopback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !col[i]);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_row
    p_one_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_flat[o*NPORT +: NPORT]));
    p_vc_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> out_ready[o*NUM_VC + int'(out_vc[o*VC_W +: VC_W])]);
    for (genvar i = 0; i < NPORT; i++) begin : g_cell
      p_grant_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_flat[o*NPORT + i] |-> req_flat[o*NPORT + i]);
      p_rotate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gnt_flat[o*NPORT + i])
         && $stable(req_flat[o*NPORT +: NPORT])
         && ($countones(req_flat[o*NPORT +: NPORT]) > 1))
        |-> !gnt_flat[o*NPORT + i]);
    end
  end
endmodule

bind hc_router hc_router_chk #(
  .NPORT(hc_pkg::NPORT), .NUM_VC(NUM_VC), .VC_W(VC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_vc   (out_vc),
  .drop_i   (drop_i),
  .req_flat (req_flat),
  .gnt_flat (gnt_flat)
);

// File: tb/tb_hc_router.sv
module tb_hc_router;
  localparam int DATA_W = 16;
  localparam int NUM_VC = 4;
  localparam int VC_W   = 2;
  localparam int FW     = DATA_W + 9;
  localparam int NP     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]        in_valid, in_ready, out_valid;
  logic [NP*VC_W-1:0]   in_vc, out_vc;
  logic [NP*FW-1:0]     in_flit, out_flit;
  logic [NP*NUM_VC-1:0] out_ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  hc_router #(.DATA_W(DATA_W), .NUM_VC(NUM_VC), .HORIZ_EAST(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_vc(in_vc), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_vc(out_vc), .out_flit(out_flit)
  );

  function automatic logic [FW-1:0] mk(bit hv, int dx, int dy, logic [15:0] pl);
    logic [3:0] x4, y4;
    x4 = 4'(dx);
    y4 = 4'(dy);
    return {hv, x4, y4, pl};
  endfunction

  task automatic check(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    in_valid  = '0;
    in_vc     = '0;
    in_flit   = '0;
    out_ready = '1;
  endtask

  task automatic put(int p, int vc, logic [FW-1:0] f);
    in_valid[p]             = 1'b1;
    in_vc[p*VC_W +: VC_W]   = VC_W'(vc);
    in_flit[p*FW +: FW]     = f;
  endtask

  task automatic expect_out(int o, int vc, logic [FW-1:0] f, string rq);
    logic [FW-1:0]   af;
    logic [VC_W-1:0] av;
    af = out_flit[o*FW +: FW];
    av = out_vc[o*VC_W +: VC_W];
    check(out_valid[o] && av == VC_W'(vc) && af == f, rq,
          $sformatf("out%0d {valid,vc,flit}", o),
          {37'd0, out_valid[o], av, af}, {37'd0, 1'b1, VC_W'(vc), f});
  endtask

  task automatic expect_quiet(int o, string rq);
    check(!out_valid[o], rq, $sformatf("out%0d valid", o), 64'(out_valid[o]), 64'd0);
  endtask

  task automatic expect_ready(int p, bit v, string rq);
    check(in_ready[p] == v, rq, $sformatf("in%0d ready", p), 64'(in_ready[p]), 64'(v));
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R10: quiet state after reset
  task automatic t_reset();
    do_reset();
    #1;
    check(out_valid == '0, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == '0, "R10", "in_ready after reset", 64'(in_ready), 64'd0);
  endtask

  // R3, R2, R1: X offset resolved first on the +X link
  task automatic t_xfirst();
    @(negedge clk); idle();
    put(0, 1, mk(1, 3, -2, 16'h1111));
    #1;
    expect_out(3, 1, mk(1, 2, -2, 16'h1111), "R3");
    expect_ready(0, 1'b1, "R1");
    @(negedge clk); idle();
    put(2, 0, mk(1, 1, 0, 16'h2222));
    #1;
    expect_out(3, 0, mk(1, 0, 0, 16'h2222), "R3");
    expect_ready(2, 1'b1, "R1");
  endtask

  // R4: Y routing and ejection
  task automatic t_yroute();
    @(negedge clk); idle();
    put(0, 0, mk(1, 0, 2, 16'h3333));
    put(3, 1, mk(1, 0, -3, 16'h4444));
    put(1, 2, mk(1, 0, 0, 16'h5555));
    #1;
    expect_out(1, 0, mk(1, 0, 1, 16'h3333), "R4");
    expect_out(2, 1, mk(1, 0, -2, 16'h4444), "R4");
    expect_out(0, 2, mk(1, 0, 0, 16'h5555), "R4");
  endtask

  // R5: no -X link here, so negative X detours vertically
  task automatic t_detour();
    @(negedge clk); idle();
    put(0, 0, mk(1, -2, 1, 16'h6666));
    put(1, 3, mk(1, -1, 0, 16'h7777));
    #1;
    expect_out(1, 0, mk(1, -2, 0, 16'h6666), "R5");
    expect_out(2, 3, mk(1, -1, 1, 16'h7777), "R5");
    @(negedge clk); idle();
    put(3, 1, mk(1, -4, -1, 16'h8888));
    put(0, 2, mk(1, -1, 0, 16'h8889));
    #1;
    expect_out(2, 1, mk(1, -4, 0, 16'h8888), "R5");
    expect_out(1, 2, mk(1, -1, -1, 16'h8889), "R5");
  endtask

  // R6: routes back to the entry port are held
  task automatic t_loop();
    @(negedge clk); idle();
    put(0, 0, mk(1, 0, 0, 16'hC0C0));
    put(3, 1, mk(1, 1, 0, 16'hC3C3));
    #1;
    expect_ready(0, 1'b0, "R6");
    expect_ready(3, 1'b0, "R6");
    check(out_valid == '0, "R6", "no output for looped flits", 64'(out_valid), 64'd0);
  endtask

  // R7: header-valid clear is consumed silently
  task automatic t_drop();
    @(negedge clk); idle();
    put(0, 0, mk(0, 1, 1, 16'hD0D0));
    #1;
    expect_ready(0, 1'b1, "R7");
    check(out_valid == '0, "R7", "no output for dropped flit", 64'(out_valid), 64'd0);
  endtask

  // R8: per-channel downstream readiness
  task automatic t_vc();
    @(negedge clk); idle();
    out_ready[3*NUM_VC + 2] = 1'b0;
    put(0, 2, mk(1, 1, 0, 16'h9999));
    #1;
    expect_ready(0, 1'b0, "R8");
    expect_quiet(3, "R8");
    @(negedge clk);
    put(2, 1, mk(1, 2, 0, 16'hAAAA));
    #1;
    expect_out(3, 1, mk(1, 1, 0, 16'hAAAA), "R8");
    expect_ready(2, 1'b1, "R8");
    expect_ready(0, 1'b0, "R8");
  endtask

  // R1: four disjoint transfers in one cycle
  task automatic t_parallel();
    @(negedge clk); idle();
    put(0, 0, mk(1, 0, 1, 16'h00B0));
    put(1, 1, mk(1, 0, -1, 16'h00B1));
    put(2, 2, mk(1, 2, 3, 16'h00B2));
    put(3, 3, mk(1, 0, 0, 16'h00B3));
    #1;
    expect_out(1, 0, mk(1, 0, 0, 16'h00B0), "R1");
    expect_out(2, 1, mk(1, 0, 0, 16'h00B1), "R1");
    expect_out(3, 2, mk(1, 1, 3, 16'h00B2), "R1");
    expect_out(0, 3, mk(1, 0, 0, 16'h00B3), "R1");
    check(in_ready == 4'hF, "R1", "all inputs ready", 64'(in_ready), 64'hF);
  endtask

  // R9: three inputs contend for the horizontal output
  task automatic t_rr();
    int order [4] = '{0, 1, 2, 0};
    do_reset();
    @(negedge clk); idle();
    put(0, 0, mk(1, 1, 0, 16'hA000));
    put(1, 0, mk(1, 1, 0, 16'hA001));
    put(2, 0, mk(1, 1, 0, 16'hA002));
    for (int c = 0; c < 4; c++) begin
      #1;
      expect_out(3, 0, mk(1, 0, 0, 16'hA000 + 16'(order[c])), "R9");
      check(in_ready == 4'(1 << order[c]), "R9", "winner ready only",
            64'(in_ready), 64'(1 << order[c]));
      @(negedge clk);
    end
    idle();
  endtask

  initial begin
    idle();
    t_reset();
    t_xfirst();
    t_yroute();
    t_detour();
    t_loop();
    t_drop();
    t_vc();
    t_parallel();
    t_rr();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule